// File: doc/BRIEF.md
# Descriptor Ring Copy Engine

The block is a single-channel copy engine. It moves data from a ring of source descriptors into buffers posted on a ring of destination descriptors. Software places descriptors in memory and advances write indices through a small register port. The engine takes source descriptors in order and copies each buffer word by word through a single memory port into the next posted destination buffer. It then writes the received length and flags into that destination descriptor, advances its read indices and pulses a completion output.

A descriptor is two 32-bit words. The first word is the buffer byte address. The second word holds the byte count in bits [15:0] and a flags word in bits [31:16]. In the flags word, bit 0 is the gather bit, bit 1 is the byte-swap bit and bits [15:4] are a 12-bit transfer tag. Descriptor `i` of a ring sits at `base + 8*i`.

A source descriptor with the gather bit set is joined to the descriptors that follow it. The whole chain lands in one destination buffer and produces one completion. Software posts a destination buffer with a count of zero. The nonzero length written back by the engine is what tells software that the slot is finished.

Top module: `dring_copy_engine`

## Requirements
- R1: A source descriptor without the gather bit copies ceil(n/4) 32-bit words, where n is its clipped byte count. The words are read from its buffer and written in order to the destination buffer at the destination read index. Bits [15:0] of the second destination word are then set to n.
- R2: Ring indices wrap by masking with (size − 1). A value written to either write-index register is stored masked the same way, so writing 9 with a size of 8 reads back as 1.
- R3: While the source read index equals the source write index and no chain is open, the engine makes no memory access.
- R4: When no destination buffer is posted (destination read index equals destination write index) and no chain is open, no source descriptor is read or consumed. Work resumes once a buffer is posted.
- R5: Descriptors with gather bit 1, followed by one with gather bit 0, form a chain. The chain's data is packed word by word into one destination buffer, its written length is the sum of the clipped counts, and it produces exactly one completion.
- R6: A descriptor whose flags bit 1 is set has the byte order reversed within every copied 32-bit word. Written-back flags bit 1 is 1 exactly when some descriptor of the chain had bit 1 set.
- R7: Written-back flags bits [15:4] carry the tag of the chain's last descriptor. Bits 3, 2 and 0 are written as 0.
- R8: The byte count of each source descriptor is clipped to the maximum-length register, which resets to 0xFFFF. Words beyond the clipped count are not written.
- R9: The destination length write-back happens in an earlier cycle than the destination read index advance. The completion pulse lasts one cycle and appears together with the advanced index.
- R10: Register word offsets are: 0 source base, 1 source size, 2 source write index, 3 source read index (read-only), 4 destination base, 5 destination size, 6 destination write index, 7 destination read index (read-only), 8 maximum length. After reset all indices read 0.
- R11: A ring of size N holds N−1 outstanding descriptors, and all of them are completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid in the cycle of the request |
| done_o | output | 1 | One-cycle completion pulse per destination buffer |

## Verification
Two things can fall in the same cycle. Software may write a write-index register while the engine is copying or deciding whether to start, and the engine advances its own read index in that same stretch. The bench provokes this by appending a second descriptor a few cycles into a running transfer. It also posts the missing destination buffer while the engine is stalled on a committed source descriptor. It judges the result by requiring that every committed descriptor completes exactly once, with the right length, tag and data, and that both read indices end equal to the write indices.

// File: rtl/ce_pkg.sv
package ce_pkg;
   localparam int FLG_GATHER = 0;
   localparam int FLG_SWAP   = 1;
   localparam int META_LSB   = 4;
   localparam int META_W     = 12;

   typedef enum logic [2:0] {
      ST_IDLE, ST_SRC_A, ST_SRC_B, ST_DST_A, ST_RD, ST_WR, ST_WB, ST_ADV
   } ce_state_e;

   typedef enum logic [3:0] {
      RA_SRC_BASE = 4'd0, RA_SRC_SIZE = 4'd1, RA_SRC_WR = 4'd2, RA_SRC_RD = 4'd3,
      RA_DST_BASE = 4'd4, RA_DST_SIZE = 4'd5, RA_DST_WR = 4'd6, RA_DST_RD = 4'd7,
      RA_MAX_LEN  = 4'd8
   } ce_reg_e;
endpackage

// File: rtl/ce_ring_ptr.sv
module ce_ring_ptr #(
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv_i,
   input  logic [IDX_W-1:0] mask_i,
   output logic [IDX_W-1:0] idx_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     idx_o <= '0;
      else if (adv_i) idx_o <= (idx_o + 1'b1) & mask_i;
   end
endmodule

// File: rtl/ce_swap.sv
module ce_swap #(
   parameter bit EN = 1'b1
) (
   input  logic        en_i,
   input  logic [31:0] d_i,
   output logic [31:0] d_o
);
   generate
      if (EN) begin : g_swap
         assign d_o = en_i ? {d_i[7:0], d_i[15:8], d_i[23:16], d_i[31:24]} : d_i;
      end else begin : g_pass
         logic unused_en;
         assign unused_en = en_i;
         assign d_o = d_i;
      end
   endgenerate
endmodule

// File: rtl/ce_regfile.sv
module ce_regfile
   import ce_pkg::*;
#(
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [3:0]       addr,
   input  logic [31:0]      wdata,
   output logic [31:0]      rdata,
   input  logic [IDX_W-1:0] src_rd,
   input  logic [IDX_W-1:0] dst_rd,
   output logic [31:0]      src_base,
   output logic [31:0]      dst_base,
   output logic [IDX_W-1:0] src_mask,
   output logic [IDX_W-1:0] dst_mask,
   output logic [IDX_W-1:0] src_wr,
   output logic [IDX_W-1:0] dst_wr,
   output logic [15:0]      max_len
);
   localparam int SZ_W = IDX_W + 1;

   logic [SZ_W-1:0] src_size, dst_size;

   assign src_mask = IDX_W'(src_size - SZ_W'(1));
   assign dst_mask = IDX_W'(dst_size - SZ_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_base <= '0;  dst_base <= '0;
         src_size <= '0;  dst_size <= '0;
         src_wr   <= '0;  dst_wr   <= '0;
         max_len  <= 16'hFFFF;
      end else if (we) begin
         case (addr)
            RA_SRC_BASE: src_base <= wdata & 32'hFFFF_FFF8;
            RA_SRC_SIZE: src_size <= wdata[SZ_W-1:0];
            RA_SRC_WR:   src_wr   <= wdata[IDX_W-1:0] & src_mask;
            RA_DST_BASE: dst_base <= wdata & 32'hFFFF_FFF8;
            RA_DST_SIZE: dst_size <= wdata[SZ_W-1:0];
            RA_DST_WR:   dst_wr   <= wdata[IDX_W-1:0] & dst_mask;
            RA_MAX_LEN:  max_len  <= wdata[15:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      case (addr)
         RA_SRC_BASE: rdata = src_base;
         RA_SRC_SIZE: rdata = 32'(src_size);
         RA_SRC_WR:   rdata = 32'(src_wr);
         RA_SRC_RD:   rdata = 32'(src_rd);
         RA_DST_BASE: rdata = dst_base;
         RA_DST_SIZE: rdata = 32'(dst_size);
         RA_DST_WR:   rdata = 32'(dst_wr);
         RA_DST_RD:   rdata = 32'(dst_rd);
         RA_MAX_LEN:  rdata = 32'(max_len);
         default:     rdata = '0;
      endcase
   end

   // R2
   wr_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == RA_SRC_WR) |=> ((src_wr & ~src_mask) == '0));
endmodule

// File: rtl/ce_engine.sv
module ce_engine
   import ce_pkg::*;
#(
   parameter int IDX_W   = 4,
   parameter bit SWAP_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [31:0]      src_base,
   input  logic [31:0]      dst_base,
   input  logic [IDX_W-1:0] src_mask,
   input  logic [IDX_W-1:0] dst_mask,
   input  logic [IDX_W-1:0] src_wr,
   input  logic [IDX_W-1:0] dst_wr,
   input  logic [15:0]      max_len,
   output logic             mem_en,
   output logic             mem_we,
   output logic [31:0]      mem_addr,
   output logic [31:0]      mem_wdata,
   input  logic [31:0]      mem_rdata,
   output logic [IDX_W-1:0] src_rd,
   output logic [IDX_W-1:0] dst_rd,
   output logic             done_o
);
   ce_state_e         st;
   logic [31:0]       s_ptr, d_ptr, data_q, data_sw;
   logic [15:0]       words_left, acc_len, clip_len;
   logic [META_W-1:0] meta_q;
   logic              swap_q, gath_q, any_swap, open_q;
   logic              src_adv, dst_adv, src_avail, dst_avail;
   logic [31:0]       src_desc, dst_desc;

   assign src_avail = (src_rd != src_wr);
   assign dst_avail = (dst_rd != dst_wr);
   assign src_desc  = src_base + (32'(src_rd) << 3);
   assign dst_desc  = dst_base + (32'(dst_rd) << 3);
   assign clip_len  = (mem_rdata[15:0] > max_len) ? max_len : mem_rdata[15:0];
   assign src_adv   = (st == ST_RD) && (words_left == '0);
   assign dst_adv   = (st == ST_ADV);

   ce_ring_ptr #(.IDX_W(IDX_W)) u_src_ptr (
      .clk(clk), .rst_n(rst_n), .adv_i(src_adv), .mask_i(src_mask), .idx_o(src_rd));
   ce_ring_ptr #(.IDX_W(IDX_W)) u_dst_ptr (
      .clk(clk), .rst_n(rst_n), .adv_i(dst_adv), .mask_i(dst_mask), .idx_o(dst_rd));
   ce_swap #(.EN(SWAP_EN)) u_swap (.en_i(swap_q), .d_i(data_q), .d_o(data_sw));

   always_comb begin
      mem_en = 1'b0;  mem_we = 1'b0;  mem_addr = '0;  mem_wdata = '0;
      case (st)
         ST_SRC_A: begin mem_en = 1'b1; mem_addr = src_desc; end
         ST_SRC_B: begin mem_en = 1'b1; mem_addr = src_desc + 32'd4; end
         ST_DST_A: begin mem_en = 1'b1; mem_addr = dst_desc; end
         ST_RD:    begin mem_en = (words_left != '0); mem_addr = s_ptr; end
         ST_WR:    begin mem_en = 1'b1; mem_we = 1'b1; mem_addr = d_ptr; mem_wdata = data_sw; end
         ST_WB: begin
            mem_en = 1'b1;  mem_we = 1'b1;  mem_addr = dst_desc + 32'd4;
            mem_wdata = {meta_q, 2'b00, any_swap, 1'b0, acc_len};
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_IDLE;  s_ptr <= '0;  d_ptr <= '0;  data_q <= '0;
         words_left <= '0;  acc_len <= '0;  meta_q <= '0;
         swap_q <= 1'b0;  gath_q <= 1'b0;  any_swap <= 1'b0;
         open_q <= 1'b0;  done_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         case (st)
            ST_IDLE:  if (src_avail && (open_q || dst_avail)) st <= ST_SRC_A;
            ST_SRC_A: begin s_ptr <= mem_rdata & 32'hFFFF_FFFC; st <= ST_SRC_B; end
            ST_SRC_B: begin
               words_left <= 16'(({1'b0, clip_len} + 17'd3) >> 2);
               acc_len    <= acc_len + clip_len;
               meta_q     <= mem_rdata[16+META_LSB +: META_W];
               swap_q     <= mem_rdata[16+FLG_SWAP];
               gath_q     <= mem_rdata[16+FLG_GATHER];
               any_swap   <= any_swap | (SWAP_EN & mem_rdata[16+FLG_SWAP]);
               st         <= open_q ? ST_RD : ST_DST_A;
            end
            ST_DST_A: begin d_ptr <= mem_rdata & 32'hFFFF_FFFC; open_q <= 1'b1; st <= ST_RD; end
            ST_RD: begin
               if (words_left == '0) st <= gath_q ? ST_IDLE : ST_WB;
               else begin data_q <= mem_rdata; st <= ST_WR; end
            end
            ST_WR: begin
               s_ptr <= s_ptr + 32'd4;  d_ptr <= d_ptr + 32'd4;
               words_left <= words_left - 16'd1;  st <= ST_RD;
            end
            ST_WB:  st <= ST_ADV;
            ST_ADV: begin
               done_o <= 1'b1;  open_q <= 1'b0;  acc_len <= '0;  any_swap <= 1'b0;
               st <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   // R9
   wb_before_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dst_adv |-> ($past(mem_we) && $past(mem_addr) == dst_desc + 32'd4));
   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   // R3
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && !src_avail) |=> !mem_en);
   // R4
   stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && !open_q && !dst_avail) |=> !mem_en);
   // R5
   we_in_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> open_q);
   // R8
   clip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WR) |-> (17'(words_left) <= ((17'(max_len) + 17'd3) >> 2)));
endmodule

// File: rtl/dring_copy_engine.sv
module dring_copy_engine #(
   parameter int IDX_W   = 4,
   parameter bit SWAP_EN = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_we,
   input  logic [3:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        mem_en,
   output logic        mem_we,
   output logic [31:0] mem_addr,
   output logic [31:0] mem_wdata,
   input  logic [31:0] mem_rdata,
   output logic        done_o
);
   generate
      if (IDX_W < 2 || IDX_W > 16) begin : g_bad_idx
         $error("dring_copy_engine: IDX_W must lie in 2..16");
      end
   endgenerate

   logic [31:0]      src_base, dst_base;
   logic [IDX_W-1:0] src_mask, dst_mask, src_wr, dst_wr, src_rd, dst_rd;
   logic [15:0]      max_len;

   ce_regfile #(.IDX_W(IDX_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
      .rdata(reg_rdata), .src_rd(src_rd), .dst_rd(dst_rd),
      .src_base(src_base), .dst_base(dst_base), .src_mask(src_mask), .dst_mask(dst_mask),
      .src_wr(src_wr), .dst_wr(dst_wr), .max_len(max_len));

   ce_engine #(.IDX_W(IDX_W), .SWAP_EN(SWAP_EN)) u_eng (
      .clk(clk), .rst_n(rst_n), .src_base(src_base), .dst_base(dst_base),
      .src_mask(src_mask), .dst_mask(dst_mask), .src_wr(src_wr), .dst_wr(dst_wr),
      .max_len(max_len), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .src_rd(src_rd), .dst_rd(dst_rd),
      .done_o(done_o));
endmodule

// File: tb/dring_copy_engine_bench.sv
module dring_copy_engine_bench;
   localparam logic [3:0] A_SB = 4'd0, A_SS = 4'd1, A_SW = 4'd2, A_SR = 4'd3;
   localparam logic [3:0] A_DB = 4'd4, A_DS = 4'd5, A_DW = 4'd6, A_DR = 4'd7, A_ML = 4'd8;
   localparam int SBASE = 32'h000, DBASE = 32'h100;

   logic clk = 1'b0, rst_n = 1'b0;
   logic reg_we = 1'b0;
   logic [3:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic mem_en, mem_we, done_o;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic [31:0] mem [0:1023];

   int n_run = 0, n_fail = 0, dones = 0, wcnt = 0;
   int sw_s = 0, sw_d = 0, ns = 8, nd = 8, gen = 0, maxlen_b = 65535;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   dring_copy_engine u_dring_copy_engine (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_en(mem_en), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done_o(done_o));

   assign mem_rdata = mem[mem_addr[11:2]];
   always @(posedge clk) begin
      if (mem_en && mem_we) begin mem[mem_addr[11:2]] <= mem_wdata; wcnt <= wcnt + 1; end
      if (done_o) dones <= dones + 1;
   end

   function automatic logic [31:0] bswap(input logic [31:0] w);
      return {w[7:0], w[15:8], w[23:16], w[31:24]};
   endfunction

   task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", r, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk); reg_addr = a; #1 d = reg_rdata;
   endtask

   task automatic wait_dones(input int target, input string r);
      int t = 0;
      while (dones < target && t < 4000) begin @(negedge clk); t++; end
      repeat (2) @(negedge clk);
      check(r, dones, target);
   endtask

   task automatic post_dst(output int slot);
      int dbuf;
      slot = sw_d;
      dbuf = 32'h800 + slot * 128;
      mem[(DBASE + slot * 8) / 4] = dbuf;
      mem[(DBASE + slot * 8) / 4 + 1] = 32'h0;
      for (int k = 0; k < 32; k++) mem[dbuf / 4 + k] = 32'hDEAD0000 + k;
      sw_d = (sw_d + 1) % nd;
      wr(A_DW, sw_d);
   endtask

   task automatic push_one(input int len, input bit sw, input bit g, input logic [11:0] meta,
                           ref logic [31:0] q[$], output int clip);
      int slot, bufa, nw;
      logic [31:0] w;
      slot = sw_s;
      bufa = 32'h400 + slot * 64;
      clip = (len > maxlen_b) ? maxlen_b : len;
      nw = (clip + 3) / 4;
      for (int k = 0; k < (len + 3) / 4; k++) begin
         w = {8'hA5, 8'(gen), 8'(slot), 8'(k)};
         mem[bufa / 4 + k] = w;
         if (k < nw) q.push_back(sw ? bswap(w) : w);
      end
      mem[(SBASE + slot * 8) / 4] = bufa;
      mem[(SBASE + slot * 8) / 4 + 1] = {meta, 2'b00, sw, g, 16'(len)};
      sw_s = (sw_s + 1) % ns;
      gen++;
   endtask

   task automatic check_buf(input string r, input int dslot, input logic [31:0] q[$], input int first);
      int dbuf, n;
      bit bad = 1'b0;
      dbuf = 32'h800 + dslot * 128;
      n = q.size() - first;
      for (int j = 0; j < n; j++) if (mem[dbuf / 4 + j] !== q[first + j]) bad = 1'b1;
      check({r, " data words"}, 32'(bad), 32'h0);
      check({r, " word past end untouched (R8)"}, mem[dbuf / 4 + n], 32'hDEAD0000 + n);
   endtask

   task automatic run_chain(input int ndsc, input int l0, input int l1, input int l2,
                            input int swm, input bit stall, input string r);
      int lens[3];
      logic [31:0] q[$];
      int total = 0, dslot = 0, base_d, clip, s0, w0;
      bit anysw = 1'b0;
      logic [11:0] meta = '0;
      logic [31:0] v;
      lens = '{l0, l1, l2};
      base_d = dones;
      s0 = sw_s;
      if (!stall) post_dst(dslot);
      for (int i = 0; i < ndsc; i++) begin
         bit sw;
         sw = (swm == 1) || (swm == 2 && i == ndsc - 1);
         meta = 12'(gen * 3 + i + 1);
         push_one(lens[i], sw, (i != ndsc - 1), meta, q, clip);
         total += clip;
         anysw |= sw;
      end
      wr(A_SW, sw_s);
      if (stall) begin
         w0 = wcnt;
         repeat (40) @(negedge clk);
         check("R4 no completion while no buffer posted", dones, base_d);
         check("R4 no memory write while stalled", wcnt, w0);
         rd(A_SR, v);
         check("R4 source read index held", v, s0);
         post_dst(dslot);
      end
      wait_dones(base_d + 1, {r, " R5 one completion per chain"});
      check({r, " R1/R6/R7 written length and flags"},
            mem[(DBASE + dslot * 8) / 4 + 1], {meta, 2'b00, anysw, 1'b0, 16'(total)});
      check_buf(r, dslot, q, 0);
      rd(A_SR, v);  check({r, " R2 source read index"}, v, sw_s);
      rd(A_DR, v);  check({r, " R2 destination read index"}, v, sw_d);
   endtask

   task automatic do_reset(input int sz);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      sw_s = 0; sw_d = 0; ns = sz; nd = sz; maxlen_b = 65535;
   endtask

   task automatic configure(input int sz);
      wr(A_SB, SBASE); wr(A_DB, DBASE); wr(A_SS, sz); wr(A_DS, sz);
   endtask

   initial begin
      #400000;
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      logic [31:0] q[$];
      int p0, p1, c, base_d, slots[3];
      for (int k = 0; k < 1024; k++) mem[k] = 32'h0;
      do_reset(8);
      // R10 reset state
      rd(A_SR, v); check("R10 source read index after reset", v, 0);
      rd(A_DR, v); check("R10 destination read index after reset", v, 0);
      rd(A_SW, v); check("R10 source write index after reset", v, 0);
      rd(A_ML, v); check("R8 max length reset value", v, 32'hFFFF);
      repeat (20) @(negedge clk);
      check("R3 no memory write while idle", wcnt, 0);
      configure(8);
      rd(A_SS, v); check("R10 source size readback", v, 8);
      rd(A_DB, v); check("R10 destination base readback", v, DBASE);
      wr(A_DW, 9);
      rd(A_DW, v); check("R2 write index masked", v, 1);
      wr(A_DW, 0);
      repeat (10) @(negedge clk);
      check("R3 still no memory write", wcnt, 0);

      // sweep: chain length, swap mode, length pattern; wraps both rings
      for (int ndsc = 1; ndsc <= 3; ndsc++)
         for (int swm = 0; swm < 3; swm++)
            for (int lp = 0; lp < 2; lp++)
               run_chain(ndsc, 4 + lp * 5 + ndsc, 9 + lp * 3, 16 - lp * 7 + swm, swm, 1'b0,
                         $sformatf("R1/R5/R6 sweep n%0d s%0d p%0d", ndsc, swm, lp));

      // R8 clipping
      wr(A_ML, 8); maxlen_b = 8;
      run_chain(1, 20, 0, 0, 0, 1'b0, "R8 clip single");
      run_chain(2, 20, 13, 0, 1, 1'b0, "R8 clip gather");
      wr(A_ML, 32'hFFFF); maxlen_b = 65535;

      // R4 stall until a buffer is posted
      run_chain(2, 12, 7, 0, 2, 1'b1, "R4 stall then post");

      // software appends while the engine copies
      base_d = dones;
      post_dst(p0); post_dst(p1);
      q.delete();
      push_one(40, 1'b0, 1'b0, 12'd1, q, c);
      wr(A_SW, sw_s);
      repeat (3) @(negedge clk);
      push_one(8, 1'b1, 1'b0, 12'd2, q, c);
      wr(A_SW, sw_s);
      wait_dones(base_d + 2, "R1 both appended descriptors complete");
      check("R1 first buffer length/tag", mem[(DBASE + p0 * 8) / 4 + 1], 32'h0010_0028);
      check("R6 second buffer swapped flag/tag", mem[(DBASE + p1 * 8) / 4 + 1], 32'h0022_0008);
      check("R6 second buffer word 0 swapped", mem[(32'h800 + p1 * 128) / 4], q[10]);
      check("R1 first buffer last word", mem[(32'h800 + p0 * 128) / 4 + 9], q[9]);
      rd(A_SR, v); check("R2 source read index after append", v, sw_s);

      // R11 full ring of size 4
      do_reset(4);
      configure(4);
      base_d = dones;
      q.delete();
      for (int i = 0; i < 3; i++) post_dst(slots[i]);
      for (int i = 0; i < 3; i++) push_one(4 * (i + 1), 1'b0, 1'b0, 12'(i + 5), q, c);
      wr(A_SW, sw_s);
      wait_dones(base_d + 3, "R11 three completions on size-4 ring");
      for (int i = 0; i < 3; i++)
         check("R11 full-ring descriptor", mem[(DBASE + slots[i] * 8) / 4 + 1],
               {12'(i + 5), 4'b0, 16'(4 * (i + 1))});
      rd(A_SR, v); check("R11 source read index", v, 3);
      rd(A_DR, v); check("R11 destination read index", v, 3);

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule